// File: doc/BRIEF.md
# SPI Command Receiver with Complement Check

This block is the serial command front end of a memory-sharing controller. An external microcontroller acts as SPI master and sends 16-bit commands that decide which side of the chip owns a shared memory: the disk-drive side or the SPI side. A command only takes effect if the next word on the link is its exact bitwise complement. A good pair is answered with a fixed acknowledge word. A bad pair sets an error flag that stays set until the host clears it.

The SPI pins are asynchronous to the system clock. The block passes them through two-flop synchronizers and finds the SCLK edges in the system clock domain. For this reason the system clock must run at no less than eight times SCLK. Each low period of the select line carries one byte. Bytes are put together into words with the most significant byte first, and the bits of each byte also arrive most significant first.

The control state machine moves through these states:
- `ST_CMD` to `ST_INV` when the last command byte arrives.
- `ST_INV` to `ST_EVAL` when the last complement byte arrives.
- `ST_EVAL` to `ST_ACK` when the complement check passes, and to `ST_CMD` when it fails.
- `ST_ACK` back to `ST_CMD` after the last acknowledge byte.

Top module: `spi_cmd_rx`

## Requirements
- R1: The SPI link runs with the clock idling high. MOSI is captured on the rising SCLK edge, most significant bit first, and one low period of select carries exactly one 8-bit byte.
- R2: If select rises after fewer than 8 rising SCLK edges, the partial byte is dropped and the transaction does not advance.
- R3: A transaction is made of two 16-bit words, each sent high byte first: the command word, then its complement word.
- R4: A command of 0x0A51 followed by 0xF5AE gives ownership to the SPI side (`own_spi` = 1).
- R5: A command of 0x0AD1 followed by 0xF52E gives ownership to the drive side (`own_spi` = 0).
- R6: Any other command that passes the complement check is acknowledged and leaves `own_spi` unchanged.
- R7: If the second word is not the exact complement of the first, `err_flag` is set, ownership is unchanged, no acknowledge is sent, and the next frame is taken as the high byte of a new command.
- R8: `err_flag` stays set until a cycle with `err_clr` high that coincides with no new mismatch. After that cycle it reads 0.
- R9: After a passing check, the next two frames shift out 0x5A and then 0x5A on MISO, changed on falling SCLK edges. The bytes the master sends in those frames are ignored.
- R10: MISO is held high while select is deasserted, and it reads 0xFF during every frame that is not an acknowledge frame.
- R11: Reset clears `err_flag`, gives ownership to the drive side and drops any partial byte or word.
- R12: The block works correctly when SCLK is at most one eighth of the system clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock from the master, idles high |
| spi_cs_n | input | 1 | Active-low frame select from the master |
| spi_sdi | input | 1 | Serial data from the master (MOSI) |
| spi_sdo | output | 1 | Serial data to the master (MISO), high when idle |
| err_clr | input | 1 | Clears the sticky error flag |
| own_spi | output | 1 | 1: SPI side owns the memory; 0: drive side owns it |
| err_flag | output | 1 | Sticky complement-mismatch flag |

## Verification
The bench builds the block with its default parameters: 16-bit words, 8-bit frames, the two ownership codes above and the acknowledge word 0x5A5A. It drives SCLK at two rates. The first uses a half period of 12 system clocks, which is close to the nominal 4 MHz link. The second uses 4 system clocks, which is exactly the 8x ratio limit, so the synchronizer latency is tested against the MISO setup window. Across these runs the bench covers several command patterns, mismatches, a frame cut short and a reset in the middle of a transaction.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_INV  = 2'd1,
        ST_EVAL = 2'd2,
        ST_ACK  = 2'd3
    } rx_state_t;

endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stage;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage <= {2{RST_VAL[i]}};
            end else begin
                stage <= {stage[0], d[i]};
            end
        end
        assign q[i] = stage[1];
    end

endmodule

// File: rtl/cmdrx_link.sv
module cmdrx_link #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              cs_n_s,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done,
    output logic              cs_act,
    output logic              sdo
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sck_d;
    logic              cs_n_d;
    logic              rise;
    logic              fall;
    logic              frame_start;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    // Edge detection on the synchronized pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d  <= 1'b1;
            cs_n_d <= 1'b1;
        end else begin
            sck_d  <= sck_s;
            cs_n_d <= cs_n_s;
        end
    end

    assign rise        = !sck_d && sck_s;
    assign fall        = sck_d && !sck_s;
    assign cs_act      = !cs_n_s;
    assign frame_start = cs_n_d && !cs_n_s;

    // Receive path: capture on rising edge, count bits within one frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
            end else if (rise) begin
                rx_sh <= {rx_sh[BYTE_W-2:0], sdi_s};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign rx_byte = rx_sh;

    // Transmit path: load at frame start, present next bit on falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '1;
            sdo   <= 1'b1;
        end else if (!cs_act) begin
            sdo <= 1'b1;
        end else if (frame_start) begin
            tx_sh <= tx_byte;
        end else if (fall) begin
            sdo   <= tx_sh[BYTE_W-1];
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
        end
    end

endmodule

// File: rtl/cmdrx_fsm.sv
module cmdrx_fsm
    import cmdrx_pkg::*;
#(
    parameter int                BYTE_W     = 8,
    parameter int                WORD_W     = 16,
    parameter logic [WORD_W-1:0] CODE_SPI   = 16'h0A51,
    parameter logic [WORD_W-1:0] CODE_DRIVE = 16'h0AD1,
    parameter logic [WORD_W-1:0] ACK_WORD   = 16'h5A5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              err_clr,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              own_spi,
    output logic              err_flag,
    output logic              in_eval,
    output logic              in_ack,
    output logic              chk_bad
);

    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    rx_state_t         state;
    rx_state_t         nxt;
    logic [IDX_W-1:0]  byte_idx;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] cmd_w;
    logic [WORD_W-1:0] acc_next;
    logic              last_byte;
    logic              pair_ok;
    logic [WORD_W-1:0] ack_sh;

    assign last_byte = (byte_idx == LAST_IDX);
    assign acc_next  = {acc[WORD_W-BYTE_W-1:0], rx_byte};
    assign pair_ok   = ((cmd_w ^ acc) == {WORD_W{1'b1}});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CMD;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_CMD:  if (byte_done && last_byte) nxt = ST_INV;
            ST_INV:  if (byte_done && last_byte) nxt = ST_EVAL;
            ST_EVAL: nxt = pair_ok ? ST_ACK : ST_CMD;
            ST_ACK:  if (byte_done && last_byte) nxt = ST_CMD;
            default: nxt = ST_CMD;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_idx <= '0;
            acc      <= '0;
            cmd_w    <= '0;
            own_spi  <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            unique case (state)
                ST_CMD: begin
                    if (byte_done) begin
                        acc      <= acc_next;
                        byte_idx <= last_byte ? '0 : byte_idx + 1'b1;
                        if (last_byte) cmd_w <= acc_next;
                    end
                end
                ST_INV: begin
                    if (byte_done) begin
                        acc      <= acc_next;
                        byte_idx <= last_byte ? '0 : byte_idx + 1'b1;
                    end
                end
                ST_EVAL: begin
                    byte_idx <= '0;
                    if (pair_ok) begin
                        if (cmd_w == CODE_SPI)        own_spi <= 1'b1;
                        else if (cmd_w == CODE_DRIVE) own_spi <= 1'b0;
                    end
                end
                ST_ACK: begin
                    if (byte_done) begin
                        byte_idx <= last_byte ? '0 : byte_idx + 1'b1;
                    end
                end
                default: byte_idx <= '0;
            endcase

            if (chk_bad) begin
                err_flag <= 1'b1;
            end else if (err_clr) begin
                err_flag <= 1'b0;
            end
        end
    end

    assign in_eval = (state == ST_EVAL);
    assign in_ack  = (state == ST_ACK);
    assign chk_bad = in_eval && !pair_ok;

    // Reply byte for the next frame: acknowledge slice in ST_ACK, idle ones otherwise
    assign ack_sh  = ACK_WORD >> ((int'(LAST_IDX) - int'(byte_idx)) * BYTE_W);
    assign tx_byte = in_ack ? ack_sh[BYTE_W-1:0] : {BYTE_W{1'b1}};

endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
    parameter int                BYTE_W     = 8,
    parameter int                WORD_W     = 16,
    parameter logic [WORD_W-1:0] CODE_SPI   = 16'h0A51,
    parameter logic [WORD_W-1:0] CODE_DRIVE = 16'h0AD1,
    parameter logic [WORD_W-1:0] ACK_WORD   = 16'h5A5A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_sdi,
    output logic spi_sdo,
    input  logic err_clr,
    output logic own_spi,
    output logic err_flag
);

    logic [2:0]        pins_s;
    logic [BYTE_W-1:0] lnk_rx_byte;
    logic [BYTE_W-1:0] fsm_tx_byte;
    logic              lnk_byte_done;
    logic              lnk_cs_act;
    logic              fsm_in_eval;
    logic              fsm_in_ack;
    logic              fsm_chk_bad;

    cmdrx_sync #(
        .W       (3),
        .RST_VAL (3'b011)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sdi, spi_cs_n, spi_sck}),
        .q     (pins_s)
    );

    cmdrx_link #(
        .BYTE_W (BYTE_W)
    ) i_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[0]),
        .sdi_s     (pins_s[2]),
        .cs_n_s    (pins_s[1]),
        .tx_byte   (fsm_tx_byte),
        .rx_byte   (lnk_rx_byte),
        .byte_done (lnk_byte_done),
        .cs_act    (lnk_cs_act),
        .sdo       (spi_sdo)
    );

    cmdrx_fsm #(
        .BYTE_W     (BYTE_W),
        .WORD_W     (WORD_W),
        .CODE_SPI   (CODE_SPI),
        .CODE_DRIVE (CODE_DRIVE),
        .ACK_WORD   (ACK_WORD)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (lnk_byte_done),
        .rx_byte   (lnk_rx_byte),
        .err_clr   (err_clr),
        .tx_byte   (fsm_tx_byte),
        .own_spi   (own_spi),
        .err_flag  (err_flag),
        .in_eval   (fsm_in_eval),
        .in_ack    (fsm_in_ack),
        .chk_bad   (fsm_chk_bad)
    );

endmodule

// File: rtl/cmdrx_chk.sv
module cmdrx_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sdo,
    input logic err_clr,
    input logic own_spi,
    input logic err_flag,
    input logic in_eval,
    input logic in_ack,
    input logic chk_bad,
    input logic byte_done,
    input logic cs_act
);

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_bad |=> err_flag); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag); // R8

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !chk_bad) |=> !err_flag); // R8

    AST_OWN_ONLY_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(own_spi) |-> $past(in_eval)); // R6

    AST_ACK_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> ($past(in_eval) && !$past(chk_bad))); // R9

    AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(cs_act)); // R2

    AST_SDO_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> spi_sdo); // R10

endmodule

bind spi_cmd_rx cmdrx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_sdo   (spi_sdo),
    .err_clr   (err_clr),
    .own_spi   (own_spi),
    .err_flag  (err_flag),
    .in_eval   (fsm_in_eval),
    .in_ack    (fsm_in_ack),
    .chk_bad   (fsm_chk_bad),
    .byte_done (lnk_byte_done),
    .cs_act    (lnk_cs_act)
);

// File: tb/test_spi_cmd_rx.sv
module test_spi_cmd_rx;

    localparam logic [15:0] C_SPI   = 16'h0A51;
    localparam logic [15:0] C_DRIVE = 16'h0AD1;
    localparam logic [15:0] C_ACK   = 16'h5A5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b1;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic clr = 1'b0;
    logic sdo;
    logic own;
    logic err;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit exp_own = 1'b0;
    bit exp_err = 1'b0;

    always #5 clk = ~clk;

    spi_cmd_rx #(
        .BYTE_W(8), .WORD_W(16),
        .CODE_SPI(C_SPI), .CODE_DRIVE(C_DRIVE), .ACK_WORD(C_ACK)
    ) i_spi_cmd_rx (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_sdi(sdi), .spi_sdo(sdo), .err_clr(clr),
        .own_spi(own), .err_flag(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model compared on every clock while the outputs are settled
    always @(negedge clk) begin
        if (cmp_en) begin
            check(own == exp_own, "R4/R5/R6 own_spi model", int'(own), int'(exp_own));
            check(err == exp_err, "R7/R8 err_flag model", int'(err), int'(exp_err));
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input int half, input logic [7:0] tx, output logic [7:0] rx);
        rx = '0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(half);
        for (int b = 7; b >= 0; b--) begin
            sck = 1'b0;
            sdi = tx[b];
            wait_clk(half);
            rx[b] = sdo;
            sck = 1'b1;
            wait_clk(half);
        end
        cs_n = 1'b1;
        wait_clk(2 * half);
    endtask

    // Sends command and second word; returns the 4 bytes seen on MISO
    task automatic send_pair(input int half, input logic [15:0] c, input logic [15:0] v,
                             output logic [31:0] seen);
        logic [7:0] r;
        cmp_en = 1'b0;
        frame(half, c[15:8], r); seen[31:24] = r;
        frame(half, c[7:0],  r); seen[23:16] = r;
        frame(half, v[15:8], r); seen[15:8]  = r;
        frame(half, v[7:0],  r); seen[7:0]   = r;
        wait_clk(4);
    endtask

    task automatic read_ack(input int half, output logic [15:0] a);
        logic [7:0] r;
        frame(half, 8'h3C, r); a[15:8] = r;
        frame(half, 8'hC3, r); a[7:0]  = r;
    endtask

    // Full good transaction with model update and acknowledge check
    task automatic good_txn(input int half, input logic [15:0] c, input string req);
        logic [31:0] seen;
        logic [15:0] a;
        send_pair(half, c, ~c, seen);
        check(seen == 32'hFFFF_FFFF, "R10 MISO idle during command frames", int'(seen), 32'hFFFF_FFFF);
        if (c == C_SPI) exp_own = 1'b1;
        else if (c == C_DRIVE) exp_own = 1'b0;
        check(own == exp_own, req, int'(own), int'(exp_own));
        read_ack(half, a);
        check(a == C_ACK, "R9 acknowledge word", int'(a), int'(C_ACK));
        cmp_en = 1'b1;
        wait_clk(10);
    endtask

    initial begin
        logic [31:0] seen;
        logic [7:0] r;
        wait_clk(5);
        check(sdo == 1'b1, "R11 MISO high in reset", int'(sdo), 1);
        rst_n = 1'b1;
        wait_clk(3);
        check(own == 1'b0, "R11 reset owner is drive", int'(own), 0);
        check(err == 1'b0, "R11 reset error clear", int'(err), 0);
        cmp_en = 1'b1;
        wait_clk(10);

        // R1 R3 R4: give memory to SPI side
        good_txn(12, C_SPI, "R4 own_spi after give-SPI");
        // R5: give back to drive side
        good_txn(12, C_DRIVE, "R5 own_spi after give-drive");
        good_txn(12, C_SPI, "R4 own_spi again");
        // R6: unknown code acknowledged, owner kept
        good_txn(12, 16'h1234, "R6 unknown code keeps owner");
        good_txn(12, 16'h0000, "R6 all-zero code keeps owner");

        // R7: mismatch sets error, no ack, owner kept
        send_pair(12, C_DRIVE, 16'hF52F, seen);
        exp_err = 1'b1;
        check(err == 1'b1, "R7 mismatch sets err_flag", int'(err), 1);
        check(own == 1'b1, "R7 owner kept on mismatch", int'(own), 1);
        cmp_en = 1'b1;
        wait_clk(10);
        // R7: next frame starts a new command (realigned)
        good_txn(12, C_DRIVE, "R7 realigned command after mismatch");

        // R8: sticky through a good command, then cleared
        check(err == 1'b1, "R8 err_flag sticky", int'(err), 1);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; exp_err = 1'b0;
        wait_clk(2);
        check(err == 1'b0, "R8 err_clr clears flag", int'(err), 0);

        // R2: partial frame discarded
        cmp_en = 1'b0;
        @(negedge clk); cs_n = 1'b0; wait_clk(12);
        for (int b = 0; b < 3; b++) begin
            sck = 1'b0; sdi = 1'b1; wait_clk(12);
            sck = 1'b1; wait_clk(12);
        end
        cs_n = 1'b1; wait_clk(24);
        cmp_en = 1'b1;
        good_txn(12, C_SPI, "R2 partial frame ignored");

        // R11: reset mid-transaction drops partial word and owner
        cmp_en = 1'b0;
        frame(12, C_DRIVE[15:8], r);
        frame(12, C_DRIVE[7:0], r);
        rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(3);
        exp_own = 1'b0; exp_err = 1'b0;
        check(own == 1'b0, "R11 owner after mid-transaction reset", int'(own), 0);
        cmp_en = 1'b1;
        good_txn(12, C_SPI, "R11 clean start after reset");

        // R12: SCLK at exactly 1/8 of system clock
        good_txn(4, C_DRIVE, "R12 give-drive at 8x ratio");
        good_txn(4, 16'hA5C3, "R12 unknown code at 8x ratio");
        send_pair(4, C_SPI, 16'h0000, seen);
        exp_err = 1'b1;
        check(err == 1'b1, "R12 mismatch detected at 8x ratio", int'(err), 1);
        cmp_en = 1'b1;
        good_txn(4, C_SPI, "R12 give-SPI at 8x ratio");

        cmp_en = 1'b0;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule